// File: doc/BRIEF.md
# Supervisory Watchdog with Retry Lockout

This block supervises a compute domain independently of it. It watches a one-cycle heartbeat kick, a power-good level and two over-temperature levels. From these it drives a safe-output force, a reset for the compute domain and a two-bit recovery state. The heartbeat is judged against a window. A kick that comes too soon is as much a fault as a kick that never comes, so a runaway loop that kicks fast cannot keep the block content.

Every fault puts the outputs in the safe state and holds the compute domain in reset. Each such reset is counted against a retry budget that is observed over a programmable time window. When the budget runs out, the block parks in a lockout state. Only an acknowledge pulse, given while power is good and the critical temperature flag is clear, releases it. Each reset also publishes a cause code, the retry count and the time of the last good heartbeat.

Time is counted in ticks of a free-running 1 ms strobe. The window bounds, the retry limit and the lockout window are sampled only while reset is held.

Top module: `guard_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `state`=2 (SAFE), `safe_force`=1, `cpu_rst`=1, `retry_cnt`=0 and `rst_cause`=7 (unknown). State codes are RUN=0, WARN=1, SAFE=2, LOCKOUT=3.
- R2: The heartbeat age is a tick count that restarts at zero on entry to RUN and on every valid kick. A kick is valid only when cfg_open <= age < cfg_close. A kick with age < cfg_open is a watchdog fault with cause 1.
- R3: In RUN or WARN, when the age reaches cfg_close, the next clock edge gives SAFE (or LOCKOUT, see R7) with `safe_force`=1, `cpu_rst`=1, `rst_cause`=1 and the retry count advanced.
- R4: In RUN, an age of at least cfg_close - cfg_close/4, or `temp_hi` high, moves the block to WARN. A valid kick with `temp_hi` low returns it to RUN on the next edge.
- R5: A low `pwr_good` in RUN or WARN is a reset with cause 2. SAFE is held, with `safe_force` and `cpu_rst` both high, until `pwr_good` has been high for PG_HOLD consecutive ticks. Only then does the block enter RUN, which clears both outputs in the same edge.
- R6: Cause codes are watchdog=1, brownout=2, external=3, software=4, thermal=5 and unknown=7. When faults coincide, the winner is chosen in this order: thermal, brownout, watchdog, external (`ext_req`), software (`sw_req`).
- R7: A reset sets `retry_cnt` to 1 if it was 0, or if at least cfg_lock_win ticks have passed since the reset that opened the current window. Otherwise it adds 1. When the new count reaches cfg_retry_max, the block enters LOCKOUT instead of SAFE.
- R8: LOCKOUT holds `safe_force` and `cpu_rst` high. It is left only on a `lock_ack` that arrives while `pwr_good`=1 and `temp_crit`=0. The exit goes to SAFE with `retry_cnt` cleared.
- R9: `temp_crit` held for OT_HOLD consecutive ticks in RUN or WARN causes LOCKOUT with cause 5 and leaves `retry_cnt` unchanged. A shorter pulse has no effect.
- R10: On each reset, `hb_stamp` takes the value of the tick time (ticks since `rst`) at the last valid kick.
- R11: Changes on the cfg inputs outside reset have no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, samples the cfg inputs |
| tick_ms | input | 1 | One-cycle 1 ms time strobe |
| hb_kick | input | 1 | Heartbeat kick pulse |
| pwr_good | input | 1 | Power-good level, low means brownout |
| ext_req | input | 1 | External reset request |
| sw_req | input | 1 | Software reset request |
| temp_hi | input | 1 | Over-temperature, degrade level |
| temp_crit | input | 1 | Over-temperature, critical level |
| lock_ack | input | 1 | Acknowledge to leave lockout |
| cfg_open | input | TW | Window open, in ticks |
| cfg_close | input | TW | Window close, in ticks |
| cfg_retry_max | input | RW | Resets allowed per window |
| cfg_lock_win | input | TW | Retry observation window, in ticks |
| state | output | 2 | Recovery state |
| safe_force | output | 1 | Forces field outputs safe |
| cpu_rst | output | 1 | Reset to the compute domain |
| rst_cause | output | 3 | Cause of the latest reset |
| retry_cnt | output | RW | Resets in the current window |
| hb_stamp | output | TW | Tick time of the last valid kick at reset |

## Verification
The checker assumes that the sampled retry limit is at least 1 and that cfg_open is below cfg_close. It also assumes that every kick, acknowledge and request lasts one cycle or is a clean level. The stimulus loads a limit of 3, an open time of 4 and a close time of 10. It changes the cfg inputs only in the middle of the run, to show that they are ignored. Kicks are placed by reading the heartbeat age from the bench's own model, so every early or in-window kick lands where it was meant to.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WARN = 2'd1,
    ST_SAFE = 2'd2,
    ST_LOCK = 2'd3
  } gs_state_e;

  typedef enum logic [2:0] {
    RC_NONE    = 3'd0,
    RC_WDOG    = 3'd1,
    RC_BROWN   = 3'd2,
    RC_EXT     = 3'd3,
    RC_SW      = 3'd4,
    RC_THERM   = 3'd5,
    RC_UNKNOWN = 3'd7
  } gs_cause_e;
endpackage

// File: rtl/gs_window.sv
// Heartbeat age counter and window judgement.
module gs_window #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          active,
  input  logic          kick,
  input  logic [TW-1:0] open_t,
  input  logic [TW-1:0] close_t,
  output logic          early,
  output logic          late,
  output logic          valid,
  output logic          warn
);
  localparam logic [TW-1:0] AMAX = {TW{1'b1}};
  logic [TW-1:0] age;

  always_comb begin
    early = kick && (age < open_t);
    late  = (age >= close_t);
    valid = kick && !early && !late;
    warn  = (age >= (close_t - (close_t >> 2)));
  end

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (!active || valid) age <= '0;
    else if (tick && age != AMAX) age <= age + 1'b1;
  end
endmodule

// File: rtl/gs_hold.sv
// Persistence counter: met once level has been high for LIMIT ticks.
module gs_hold #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic level,
  input  logic clr,
  output logic met
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign met = (cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr || !level) cnt <= '0;
    else if (tick && !met) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gs_budget.sv
// Retry counter with a time-windowed budget.
module gs_budget #(
  parameter int RW = 4,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          evt,
  input  logic          clr,
  input  logic [RW-1:0] max_c,
  input  logic [TW-1:0] win,
  output logic [RW-1:0] cnt,
  output logic          lock_hit
);
  localparam logic [RW-1:0] CMAX = {RW{1'b1}};
  localparam logic [TW-1:0] LMAX = {TW{1'b1}};
  logic [TW-1:0] lw;
  logic          restart;
  logic [RW-1:0] nxt;

  always_comb begin
    restart  = (cnt == '0) || (lw >= win);
    if (restart)          nxt = RW'(1);
    else if (cnt == CMAX) nxt = cnt;
    else                  nxt = cnt + 1'b1;
    lock_hit = (nxt >= max_c);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      lw  <= '0;
    end else begin
      if (tick && cnt != '0 && lw != LMAX) lw <= lw + 1'b1;
      if (evt) begin
        cnt <= nxt;
        if (restart) lw <= '0;
      end
    end
  end
endmodule

// File: rtl/guard_supervisor.sv
module guard_supervisor
  import gs_pkg::*;
#(
  parameter int TW      = 16,
  parameter int RW      = 4,
  parameter int PG_HOLD = 3,
  parameter int OT_HOLD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          hb_kick,
  input  logic          pwr_good,
  input  logic          ext_req,
  input  logic          sw_req,
  input  logic          temp_hi,
  input  logic          temp_crit,
  input  logic          lock_ack,
  input  logic [TW-1:0] cfg_open,
  input  logic [TW-1:0] cfg_close,
  input  logic [RW-1:0] cfg_retry_max,
  input  logic [TW-1:0] cfg_lock_win,
  output logic [1:0]    state,
  output logic          safe_force,
  output logic          cpu_rst,
  output logic [2:0]    rst_cause,
  output logic [RW-1:0] retry_cnt,
  output logic [TW-1:0] hb_stamp
);
  // configuration, sampled only while reset is held
  logic [TW-1:0] open_q, close_q, win_q;
  logic [RW-1:0] max_q;

  logic [TW-1:0] now_q, last_hb_q, stamp_q;
  gs_state_e     st_q, nxt_st;
  gs_cause_e     cause_q, code;
  logic          safe_q, crst_q;

  logic active, wd_early, wd_late, wd_valid, wd_warn;
  logic pg_met, ot_met, lock_hit, evt, leave_lock;

  assign active     = (st_q == ST_RUN) || (st_q == ST_WARN);
  assign leave_lock = (st_q == ST_LOCK) && lock_ack && pwr_good && !temp_crit;

  gs_window #(.TW(TW)) u_window (
    .clk(clk), .rst(rst), .tick(tick_ms), .active(active), .kick(hb_kick),
    .open_t(open_q), .close_t(close_q),
    .early(wd_early), .late(wd_late), .valid(wd_valid), .warn(wd_warn)
  );

  gs_hold #(.LIMIT(PG_HOLD)) u_pg_hold (
    .clk(clk), .rst(rst), .tick(tick_ms), .level(pwr_good),
    .clr(st_q != ST_SAFE), .met(pg_met)
  );

  gs_hold #(.LIMIT(OT_HOLD)) u_ot_hold (
    .clk(clk), .rst(rst), .tick(tick_ms), .level(temp_crit),
    .clr(!active), .met(ot_met)
  );

  // fault selection by fixed priority
  always_comb begin
    code = RC_NONE;
    if (ot_met)                  code = RC_THERM;
    else if (!pwr_good)          code = RC_BROWN;
    else if (wd_early || wd_late) code = RC_WDOG;
    else if (ext_req)            code = RC_EXT;
    else if (sw_req)             code = RC_SW;
  end

  assign evt = active && (code != RC_NONE) && (code != RC_THERM);

  gs_budget #(.RW(RW), .TW(TW)) u_budget (
    .clk(clk), .rst(rst), .tick(tick_ms), .evt(evt), .clr(leave_lock),
    .max_c(max_q), .win(win_q), .cnt(retry_cnt), .lock_hit(lock_hit)
  );

  always_comb begin
    nxt_st = st_q;
    case (st_q)
      ST_RUN, ST_WARN: begin
        if (code == RC_THERM)     nxt_st = ST_LOCK;
        else if (code != RC_NONE) nxt_st = lock_hit ? ST_LOCK : ST_SAFE;
        else if (wd_valid)        nxt_st = temp_hi ? ST_WARN : ST_RUN;
        else                      nxt_st = (wd_warn || temp_hi) ? ST_WARN : ST_RUN;
      end
      ST_SAFE: if (pwr_good && pg_met) nxt_st = ST_RUN;
      default: if (leave_lock) nxt_st = ST_SAFE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= cfg_open;
      close_q   <= cfg_close;
      max_q     <= cfg_retry_max;
      win_q     <= cfg_lock_win;
      now_q     <= '0;
      last_hb_q <= '0;
      stamp_q   <= '0;
      st_q      <= ST_SAFE;
      safe_q    <= 1'b1;
      crst_q    <= 1'b1;
      cause_q   <= RC_UNKNOWN;
    end else begin
      now_q <= now_q + {{(TW-1){1'b0}}, tick_ms};
      if (active && wd_valid) last_hb_q <= now_q;
      st_q <= nxt_st;
      if (active && code != RC_NONE) begin
        safe_q  <= 1'b1;
        crst_q  <= 1'b1;
        cause_q <= code;
        stamp_q <= last_hb_q;
      end else if (st_q == ST_SAFE && pwr_good && pg_met) begin
        safe_q <= 1'b0;
        crst_q <= 1'b0;
      end
    end
  end

  assign state      = st_q;
  assign safe_force = safe_q;
  assign cpu_rst    = crst_q;
  assign rst_cause  = cause_q;
  assign hb_stamp   = stamp_q;
endmodule

// File: rtl/gs_checker.sv
module gs_checker
  import gs_pkg::*;
#(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pwr_good,
  input logic          lock_ack,
  input logic          active,
  input logic          early,
  input logic          late,
  input logic [1:0]    state,
  input logic          safe_force,
  input logic          cpu_rst,
  input logic [2:0]    cause,
  input logic [RW-1:0] retry_cnt,
  input logic [RW-1:0] max_q
);
  p_early_kick_r2: assert property (@(posedge clk) disable iff (rst)
    active && early |=> safe_force && cpu_rst);

  p_timeout_r3: assert property (@(posedge clk) disable iff (rst)
    active && late |=> (state == ST_SAFE || state == ST_LOCK));

  p_fault_outputs_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN || state == ST_WARN) ##1 state == ST_SAFE
      |-> safe_force && cpu_rst && cause inside {3'd1, 3'd2, 3'd3, 3'd4});

  p_brownout_safe_r5: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> safe_force && cpu_rst);

  p_safe_hold_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_SAFE && !pwr_good |=> state != ST_RUN);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    retry_cnt <= max_q);

  p_lock_stay_r8: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOCK && !lock_ack |=> state == ST_LOCK && safe_force && cpu_rst);

  p_lock_exit_r8: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOCK ##1 state != ST_LOCK |-> state == ST_SAFE && retry_cnt == '0);
endmodule

bind guard_supervisor gs_checker #(.RW(RW)) u_gs_checker (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .lock_ack(lock_ack),
  .active(active), .early(wd_early), .late(wd_late), .state(state),
  .safe_force(safe_force), .cpu_rst(cpu_rst), .cause(rst_cause),
  .retry_cnt(retry_cnt), .max_q(max_q)
);

// File: tb/test_guard_supervisor.sv
`timescale 1ns/1ps
module test_guard_supervisor;
  localparam int TW = 16, RW = 4, PGH = 3, OTH = 4;
  localparam int OPEN = 4, CLOSE = 10, RMAX = 3, LWIN = 60;

  logic clk = 1'b0, rst = 1'b1, tick_ms = 1'b0, hb_kick = 1'b0, pwr_good = 1'b0;
  logic ext_req = 1'b0, sw_req = 1'b0, temp_hi = 1'b0, temp_crit = 1'b0, lock_ack = 1'b0;
  logic [TW-1:0] cfg_open = TW'(OPEN), cfg_close = TW'(CLOSE), cfg_lock_win = TW'(LWIN);
  logic [RW-1:0] cfg_retry_max = RW'(RMAX);
  logic [1:0] state;
  logic safe_force, cpu_rst;
  logic [2:0] rst_cause;
  logic [RW-1:0] retry_cnt;
  logic [TW-1:0] hb_stamp;

  guard_supervisor #(.TW(TW), .RW(RW), .PG_HOLD(PGH), .OT_HOLD(OTH)) i_guard_supervisor (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .hb_kick(hb_kick), .pwr_good(pwr_good),
    .ext_req(ext_req), .sw_req(sw_req), .temp_hi(temp_hi), .temp_crit(temp_crit),
    .lock_ack(lock_ack), .cfg_open(cfg_open), .cfg_close(cfg_close),
    .cfg_retry_max(cfg_retry_max), .cfg_lock_win(cfg_lock_win), .state(state),
    .safe_force(safe_force), .cpu_rst(cpu_rst), .rst_cause(rst_cause),
    .retry_cnt(retry_cnt), .hb_stamp(hb_stamp)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, exp_stamp = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick strobe every other cycle
  always @(negedge clk) tick_ms <= rst ? 1'b0 : !tick_ms;

  // behavioural reference model (0 RUN, 1 WARN, 2 SAFE, 3 LOCKOUT)
  int m_st, m_safe, m_crst, m_cause, m_stamp, m_now, m_hb, m_age, m_cnt, m_lw, m_pg, m_ot;
  int m_open, m_close, m_max, m_win;
  always @(posedge clk) begin
    if (rst) begin
      m_st = 2; m_safe = 1; m_crst = 1; m_cause = 7; m_stamp = 0; m_now = 0; m_hb = 0;
      m_age = 0; m_cnt = 0; m_lw = 0; m_pg = 0; m_ot = 0;
      m_open = cfg_open; m_close = cfg_close; m_max = cfg_retry_max; m_win = cfg_lock_win;
    end else begin
      bit act, early, late, valid, warnl;
      int code, n_st, n_age, n_pg, n_ot, n_lw, n_cnt, n_hb;
      act   = (m_st < 2);
      early = hb_kick && (m_age < m_open);
      late  = (m_age >= m_close);
      valid = hb_kick && !early && !late;
      warnl = (m_age >= m_close - m_close / 4);
      n_st = m_st; n_cnt = m_cnt; n_hb = m_hb;
      n_age = (!act || valid) ? 0 : (tick_ms ? m_age + 1 : m_age);
      n_pg  = (m_st != 2 || !pwr_good) ? 0 : ((tick_ms && m_pg < PGH) ? m_pg + 1 : m_pg);
      n_ot  = (!act || !temp_crit) ? 0 : ((tick_ms && m_ot < OTH) ? m_ot + 1 : m_ot);
      n_lw  = (m_cnt != 0 && tick_ms) ? m_lw + 1 : m_lw;
      if (act && valid) n_hb = m_now;
      code = 0;
      if (act) begin
        if (m_ot >= OTH) code = 5;
        else if (!pwr_good) code = 2;
        else if (early || late) code = 1;
        else if (ext_req) code = 3;
        else if (sw_req) code = 4;
      end
      if (code == 5) begin
        n_st = 3; m_safe = 1; m_crst = 1; m_cause = 5; m_stamp = m_hb;
      end else if (code != 0) begin
        if (m_cnt == 0 || m_lw >= m_win) begin n_cnt = 1; n_lw = 0; end
        else n_cnt = m_cnt + 1;
        n_st = (n_cnt >= m_max) ? 3 : 2;
        m_safe = 1; m_crst = 1; m_cause = code; m_stamp = m_hb;
      end else if (act) begin
        n_st = (valid ? temp_hi : (warnl || temp_hi)) ? 1 : 0;
      end else if (m_st == 2) begin
        if (pwr_good && m_pg >= PGH) begin n_st = 0; m_safe = 0; m_crst = 0; end
      end else if (lock_ack && pwr_good && !temp_crit) begin
        n_st = 2; n_cnt = 0; n_lw = 0;
      end
      m_now = (m_now + (tick_ms ? 1 : 0)) & 16'hFFFF;
      m_st = n_st; m_age = n_age; m_pg = n_pg; m_ot = n_ot; m_lw = n_lw;
      m_cnt = n_cnt; m_hb = n_hb;
    end
  end

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(state == m_st, "R4 state vs model", state, m_st);
      chk(safe_force == m_safe && cpu_rst == m_crst, "R5 safe/reset vs model",
          {safe_force, cpu_rst}, {m_safe[0], m_crst[0]});
      chk(rst_cause == m_cause, "R6 cause vs model", rst_cause, m_cause);
      chk(retry_cnt == m_cnt, "R7 retry vs model", retry_cnt, m_cnt);
      chk(hb_stamp == m_stamp, "R10 stamp vs model", hb_stamp, m_stamp);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_st(input int s, input int lim, input string tag);
    int n = 0;
    while (state !== s && n < lim) begin @(negedge clk); n++; end
    chk(state == s, tag, state, s);
  endtask

  task automatic kick_valid();
    int n = 0;
    while (!(m_age >= OPEN + 1 && m_age <= CLOSE - 2) && n < 200) begin @(negedge clk); n++; end
    exp_stamp = m_now;
    hb_kick = 1'b1; @(negedge clk); hb_kick = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(state == 2 && safe_force && cpu_rst, "R1 reset outputs", {state, safe_force, cpu_rst}, 11);
    chk(retry_cnt == 0 && rst_cause == 7, "R1 reset cause/retry", rst_cause, 7);
    // R5 held in SAFE without power good
    repeat (40) @(negedge clk);
    chk(state == 2 && cpu_rst, "R5 hold while pg low", state, 2);
    pwr_good = 1'b1;
    wait_st(0, 40, "R5 release after pg stable");
    chk(!safe_force && !cpu_rst, "R5 outputs released", {safe_force, cpu_rst}, 0);
    // R2 valid kicks keep RUN
    for (int i = 0; i < 3; i++) begin
      kick_valid();
      chk(state == 0, "R2 valid kick keeps RUN", state, 0);
    end
    chk(rst_cause == 7 && retry_cnt == 0, "R2 no reset on valid kicks", retry_cnt, 0);
    // R4 WARN then kick back to RUN
    wait_st(1, 40, "R4 enter WARN on age");
    hb_kick = 1'b1; exp_stamp = m_now; @(negedge clk); hb_kick = 1'b0;
    chk(state == 0, "R4 kick returns to RUN", state, 0);
    // R3 timeout
    wait_st(2, 60, "R3 timeout reaches SAFE");
    chk(rst_cause == 1 && retry_cnt == 1, "R3 timeout cause", rst_cause, 1);
    chk(hb_stamp == exp_stamp, "R10 stamp is last kick time", hb_stamp, exp_stamp);
    // R2 early kick
    wait_st(0, 40, "R5 restart after timeout");
    while (m_age != 1) @(negedge clk);
    hb_kick = 1'b1; @(negedge clk); hb_kick = 1'b0;
    chk(state == 2 && rst_cause == 1 && retry_cnt == 2, "R2 early kick is a fault", retry_cnt, 2);
    // R11 cfg changes ignored; R7 third reset locks
    wait_st(0, 40, "R5 restart after early kick");
    cfg_retry_max = 4'd9; cfg_open = '0; cfg_close = 16'd200; cfg_lock_win = 16'd1;
    ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    chk(state == 3, "R11 sampled retry limit still applies", state, 3);
    chk(rst_cause == 3 && retry_cnt == 3, "R7 budget exhausted", retry_cnt, 3);
    // R8 lockout exit
    pwr_good = 1'b0; lock_ack = 1'b1; @(negedge clk); lock_ack = 1'b0;
    repeat (10) @(negedge clk);
    chk(state == 3 && safe_force && cpu_rst, "R8 ack without pg ignored", state, 3);
    pwr_good = 1'b1; @(negedge clk);
    lock_ack = 1'b1; @(negedge clk); lock_ack = 1'b0;
    chk(state == 2 && retry_cnt == 0, "R8 ack leaves to SAFE", retry_cnt, 0);
    wait_st(0, 40, "R8 SAFE then RUN");
    // R6 priority ext over sw
    ext_req = 1'b1; sw_req = 1'b1; @(negedge clk); ext_req = 1'b0; sw_req = 1'b0;
    chk(rst_cause == 3 && retry_cnt == 1, "R6 external beats software", rst_cause, 3);
    wait_st(0, 40, "R5 restart");
    sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
    chk(rst_cause == 4 && retry_cnt == 2, "R6 software cause", rst_cause, 4);
    wait_st(0, 40, "R5 restart");
    for (int i = 0; i < 14; i++) kick_valid();
    // R7 window restart
    pwr_good = 1'b0; @(negedge clk);
    chk(rst_cause == 2 && retry_cnt == 1 && state == 2, "R7 window expired restarts count", retry_cnt, 1);
    repeat (20) @(negedge clk);
    chk(state == 2, "R5 SAFE during brownout", state, 2);
    pwr_good = 1'b1;
    wait_st(0, 40, "R5 restart after brownout");
    // R9 thermal
    kick_valid();
    temp_hi = 1'b1; @(negedge clk);
    chk(state == 1, "R9 degrade to WARN on temp_hi", state, 1);
    temp_hi = 1'b0; @(negedge clk);
    chk(state == 0, "R9 RUN after temp_hi clears", state, 0);
    kick_valid();
    temp_crit = 1'b1; repeat (2) @(negedge clk); temp_crit = 1'b0; @(negedge clk);
    chk(state == 0, "R9 short critical pulse ignored", state, 0);
    kick_valid();
    temp_crit = 1'b1;
    wait_st(3, 40, "R9 persistent critical locks");
    chk(rst_cause == 5 && retry_cnt == 1, "R9 thermal cause, retry kept", rst_cause, 5);
    lock_ack = 1'b1; @(negedge clk); lock_ack = 1'b0;
    chk(state == 3, "R8 ack while hot ignored", state, 3);
    temp_crit = 1'b0; @(negedge clk);
    lock_ack = 1'b1; @(negedge clk); lock_ack = 1'b0;
    chk(state == 2 && retry_cnt == 0, "R8 exit after cool down", state, 2);
    wait_st(0, 40, "R8 back to RUN");
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule